// File: doc/BRIEF.md
# Converter Serial Port with End-of-Conversion Flag

This block is the digital serial port of a slow data converter. The port acts as a slave: the host drives an active-low select (`cs_n`), a serial clock (`sck`) and a data input (`sdi`), and reads `sdo`. A stub conversion timer stands in for the analog core. When it expires, the block captures the parallel result word from `result_in` into a shift register and moves from conversion to sleep.

While selected, the host reads `sdo` as a busy flag: 1 while a conversion runs, 0 once a result is waiting. In sleep, the first rising `sck` edge with select low starts a transfer frame. During that frame the held result leaves MSB first on `sdo`, and a channel address enters on `sdi`. When the frame ends, or when select rises partway through it, a new conversion starts.

Keeping select low all the time gives back-to-back conversions, each followed by one frame. The clock-mode flag is sampled at every falling edge of select. Serial transfers only run in the external-clock mode. All pins are assumed to be already synchronised to `clk`.

Top module: `cnv_serial_port`

## Requirements
- R1: `sdo_en` is 0 whenever `cs_n` has been high for the previous clock, so the line can be shared. It is 1 one clock after `cs_n` is sampled low.
- R2: With select low, `sdo` reads 1 during conversion and abort, and 0 in sleep. A conversion lasts `CONV_CYCLES` clocks.
- R3: After a conversion the block holds its result in sleep until the first rising `sck` edge seen with `cs_n` low. `sck` edges while `cs_n` is high leave the state unchanged.
- R4: A frame is `RES_W+1` rising `sck` edges. Rising edge 1 opens the frame. Each falling edge puts the next result bit on `sdo`, starting with bit `RES_W-1`. The host therefore reads bit `RES_W-k` just before rising edge k+1.
- R5: The first `ADDR_W` rising edges of a frame sample `sdi`, MSB first. The complete address appears on `chan_addr` after rising edge `ADDR_W`.
- R6: A rise of `cs_n` during a frame ends the frame and starts a fresh conversion. That conversion captures `result_in` anew.
- R7: If `cs_n` rises before the `ADDR_W`-th address edge, `chan_addr` keeps its previous value. If it rises after that edge, the new address stays.
- R8: `sck` edges and `sdi` values during a conversion change neither `chan_addr` nor the conversion state.
- R9: On every falling edge of `cs_n`, `ext_clk_mode` becomes 1 if `sck` is low and 0 if `sck` is high. With `ext_clk_mode` 0, `sck` edges do not open a frame.
- R10: After the last rising edge of a frame, a new conversion starts with no select toggle. Select held low thus gives continuous conversions.
- R11: Reset is synchronous and active low. It leaves `sdo_en`=0, `chan_addr`=0 and `ext_clk_mode`=1, and the first conversion starts on release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial address input |
| result_in | input | RES_W | Parallel conversion result |
| sdo | output | 1 | Serial data or end-of-conversion flag |
| sdo_en | output | 1 | Drive enable for `sdo` (0 = high impedance) |
| chan_addr | output | ADDR_W | Last fully received channel address |
| ext_clk_mode | output | 1 | Clock mode latched at the last select fall |

## Verification
The bench goes through every address with its own result pattern in a continuous-select run, plus all-ones, all-zeros and single-bit results. A design that shifts on the wrong edge or sends LSB first would return rotated or mirrored words. It aborts frames one edge short of and exactly at the address length. A design that commits bits early would change the address, and one that discards on the boundary edge would lose a good address. It also clocks the port during conversion, with select high in sleep, and after a select fall taken with `sck` high. A design that lets any of those open a frame would show 0 or data where the busy flag or the held MSB is due.

// File: rtl/csp_pkg.sv
// Shared types for the converter serial port.
// Assumes nothing beyond IEEE 1800-2017 enums.
package csp_pkg;

    // Port sequencing states; the encoding is internal only.
    typedef enum logic [1:0] {
        ST_CONV  = 2'd0,
        ST_SLEEP = 2'd1,
        ST_XFER  = 2'd2,
        ST_ABORT = 2'd3
    } csp_state_e;

endpackage

// File: rtl/csp_edge_det.sv
// Registers one pin and reports its rising and falling edges against the
// previous clock. Assumes the pin is already synchronous to clk.
module csp_edge_det #(
    parameter logic RST_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level_q,
    output logic rise,
    output logic fall
);

    // Holds the pin level of the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= RST_LEVEL;
        else        level_q <= din;
    end

    assign rise = din & ~level_q;
    assign fall = ~din & level_q;

endmodule

// File: rtl/csp_conv_timer.sv
// Stub conversion timer: counts while run is high and flags done in the
// last cycle. It clears whenever run drops. Assumes CONV_CYCLES >= 2.
module csp_conv_timer #(
    parameter int CONV_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Counts conversion clocks and restarts from zero outside conversion.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)   cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == LAST);

    // The done flag may appear only in the cycle the count reaches its end.
    a_r2_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run && cnt == LAST && !$past(done)));

endmodule

// File: rtl/csp_seq.sv
// State sequencer for the serial port: conversion, sleep, transfer and
// abort. It also latches the clock mode at each select fall. Assumes the
// edge flags come from csp_edge_det in the same clock domain.
module csp_seq
    import csp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck_q,
    input  logic       cs_rise,
    input  logic       cs_fall,
    input  logic       sck_rise,
    input  logic       sck_fall,
    input  logic       conv_done,
    input  logic       frame_last,
    output csp_state_e state,
    output logic       ext_mode,
    output logic       enter,
    output logic       xfer_rise,
    output logic       xfer_fall
);

    csp_state_e state_nx;

    assign enter     = (state == ST_SLEEP) && !cs_n && sck_rise && ext_mode;
    assign xfer_rise = (state == ST_XFER) && !cs_n && sck_rise;
    assign xfer_fall = (state == ST_XFER) && !cs_n && sck_fall;

    // Chooses the next state from the select, clock and timer events.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_CONV:  if (conv_done) state_nx = ST_SLEEP;
            ST_SLEEP: if (enter)     state_nx = ST_XFER;
            ST_XFER: begin
                if (cs_rise)                      state_nx = ST_ABORT;
                else if (xfer_rise && frame_last) state_nx = ST_CONV;
            end
            ST_ABORT: state_nx = ST_CONV;
            default:  state_nx = ST_CONV;
        endcase
    end

    // State register; reset starts a conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_CONV;
        else        state <= state_nx;
    end

    // Latches the clock mode from the serial clock level at a select fall.
    always_ff @(posedge clk) begin
        if (!rst_n)       ext_mode <= 1'b1;
        else if (cs_fall) ext_mode <= ~sck_q;
    end

    // Sleep persists unless a qualified clock edge arrives.
    a_r3_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && (cs_n || !sck_rise)) |=> state == ST_SLEEP);

    // A select rise inside a frame always leads to abort.
    a_r6_abort_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && cs_rise) |=> state == ST_ABORT);

    // Sleep is entered only from a finished conversion.
    a_r2_sleep_from_conv: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_SLEEP) |-> $past(state == ST_CONV && conv_done));

    // Abort lasts a single cycle and is followed by conversion.
    a_r6_abort_to_conv: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ABORT |=> state == ST_CONV);

endmodule

// File: rtl/csp_shift_path.sv
// Data path of a transfer frame: result shift register, bit counter,
// address collector and committed address. Assumes 2 <= ADDR_W <= RES_W+1.
module csp_shift_path #(
    parameter int RES_W  = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_xfer,
    input  logic              load,
    input  logic              enter,
    input  logic              xfer_rise,
    input  logic              xfer_fall,
    input  logic              sdi,
    input  logic [RES_W-1:0]  result_in,
    output logic              sdo_bit,
    output logic              frame_last,
    output logic [ADDR_W-1:0] addr_q
);

    localparam int CNT_W = $clog2(RES_W + 2);
    localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(RES_W);
    localparam logic [CNT_W-1:0] ADDR_LEN  = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] ADDR_END  = CNT_W'(ADDR_W - 1);

    logic [CNT_W-1:0]  rcnt;
    logic [ADDR_W-1:0] ashift;
    logic [RES_W-1:0]  sreg;
    logic              accept;

    assign accept     = enter | xfer_rise;
    assign frame_last = (rcnt == LAST_EDGE);

    // Counts accepted rising edges of the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n)        rcnt <= '0;
        else if (accept)   rcnt <= rcnt + 1'b1;
        else if (!in_xfer) rcnt <= '0;
    end

    // Collects address bits during the first ADDR_W edges.
    always_ff @(posedge clk) begin
        if (!rst_n)                         ashift <= '0;
        else if (accept && rcnt < ADDR_LEN) ashift <= {ashift[ADDR_W-2:0], sdi};
    end

    // Commits the address only when its final bit arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)                          addr_q <= '0;
        else if (accept && rcnt == ADDR_END) addr_q <= {ashift[ADDR_W-2:0], sdi};
    end

    // Holds the captured result and shifts it toward the MSB on falls.
    always_ff @(posedge clk) begin
        if (!rst_n)         sreg <= '0;
        else if (load)      sreg <= result_in;
        else if (xfer_fall) sreg <= {sreg[RES_W-2:0], 1'b0};
    end

    // Presents the next result bit on each falling clock of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_xfer) sdo_bit <= 1'b0;
        else if (xfer_fall)     sdo_bit <= sreg[RES_W-1];
    end

    // The address can only move on an accepted frame edge.
    a_r8_addr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(addr_q));

    // The edge counter never runs past the frame length inside a frame.
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        in_xfer |-> rcnt <= LAST_EDGE);

    // The result register changes only on a load or a frame fall.
    a_r3_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !xfer_fall) |=> $stable(sreg));

endmodule

// File: rtl/cnv_serial_port.sv
// Top of the converter serial port. It wires the pin edge detectors, the
// stub conversion timer, the sequencer and the frame data path, and it
// forms the shared sdo pin with its drive enable. Assumes all pins are
// synchronous to clk and that the host holds each sck level for at least
// one clock.
module cnv_serial_port
    import csp_pkg::*;
#(
    parameter int RES_W       = 16,
    parameter int ADDR_W      = 5,
    parameter int CONV_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              sdi,
    input  logic [RES_W-1:0]  result_in,
    output logic              sdo,
    output logic              sdo_en,
    output logic [ADDR_W-1:0] chan_addr,
    output logic              ext_clk_mode
);

    logic cs_q, cs_rise, cs_fall;
    logic sck_q, sck_rise, sck_fall;
    logic conv_done, frame_last, enter, xfer_rise, xfer_fall, sdo_bit;
    csp_state_e state;

    csp_edge_det #(.RST_LEVEL(1'b1)) u_cs_edge (
        .clk(clk), .rst_n(rst_n), .din(cs_n),
        .level_q(cs_q), .rise(cs_rise), .fall(cs_fall)
    );

    csp_edge_det #(.RST_LEVEL(1'b0)) u_sck_edge (
        .clk(clk), .rst_n(rst_n), .din(sck),
        .level_q(sck_q), .rise(sck_rise), .fall(sck_fall)
    );

    csp_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(state == ST_CONV), .done(conv_done)
    );

    csp_seq u_seq (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_q(sck_q),
        .cs_rise(cs_rise), .cs_fall(cs_fall),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .conv_done(conv_done), .frame_last(frame_last),
        .state(state), .ext_mode(ext_clk_mode), .enter(enter),
        .xfer_rise(xfer_rise), .xfer_fall(xfer_fall)
    );

    csp_shift_path #(.RES_W(RES_W), .ADDR_W(ADDR_W)) u_path (
        .clk(clk), .rst_n(rst_n), .in_xfer(state == ST_XFER),
        .load(conv_done), .enter(enter),
        .xfer_rise(xfer_rise), .xfer_fall(xfer_fall),
        .sdi(sdi), .result_in(result_in),
        .sdo_bit(sdo_bit), .frame_last(frame_last), .addr_q(chan_addr)
    );

    // Drives the pin only after select has been sampled low.
    assign sdo_en = ~cs_q;

    // Selects the busy flag or the frame data for the sdo pin.
    always_comb begin
        unique case (state)
            ST_SLEEP: sdo = 1'b0;
            ST_XFER:  sdo = sdo_bit;
            default:  sdo = 1'b1;
        endcase
    end

    // The pin is released while select stays high.
    a_r1_release: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !sdo_en);

    // A frame start requires select low and a rising serial clock.
    a_r3_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_XFER) |-> $past(!cs_n && sck_rise));

    // Sleep shows a cleared busy flag on the pin.
    a_r2_sleep_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_SLEEP) |-> !sdo);

endmodule

// File: tb/cnv_serial_port_tb.sv
module cnv_serial_port_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int RES_W      = 16;
    localparam int ADDR_W     = 5;
    localparam int CONV       = 40;

    logic clk = 1'b0;
    logic rst_n, cs_n, sck, sdi;
    logic [RES_W-1:0]  result_in;
    logic              sdo, sdo_en, ext_clk_mode;
    logic [ADDR_W-1:0] chan_addr;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cnv_serial_port #(.RES_W(RES_W), .ADDR_W(ADDR_W), .CONV_CYCLES(CONV)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .result_in(result_in), .sdo(sdo), .sdo_en(sdo_en),
        .chan_addr(chan_addr), .ext_clk_mode(ext_clk_mode)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic d);
        sdi = d; sck = 1'b1; tick(2);
        sck = 1'b0; tick(2);
    endtask

    // One full frame from sleep; checks R4 data, R5 address, R10 restart.
    task automatic frame(input logic [ADDR_W-1:0] a, input logic [RES_W-1:0] exp);
        logic [RES_W-1:0] got;
        got = '0;
        for (int k = 0; k <= RES_W; k++) begin
            if (k >= 1) got[RES_W-k] = sdo;
            pulse((k < ADDR_W) ? a[ADDR_W-1-k] : k[0]);
        end
        check("R4 result MSB first", 32'(got), 32'(exp));
        tick(1);
        check("R5 address captured", 32'(chan_addr), 32'(a));
        check("R10 new conversion busy", 32'(sdo), 32'd1);
    endtask

    function automatic logic [RES_W-1:0] pat(input int i);
        return RES_W'(i * 16'h2F1B) ^ 16'hC3A5;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [RES_W-1:0] edge_vals [4];
        edge_vals[0] = '1; edge_vals[1] = '0;
        edge_vals[2] = 16'h8000; edge_vals[3] = 16'h0001;
        rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0; result_in = pat(100);
        tick(3);
        check("R11 reset sdo_en", 32'(sdo_en), 32'd0);
        check("R11 reset chan_addr", 32'(chan_addr), 32'd0);
        check("R11 reset ext mode", 32'(ext_clk_mode), 32'd1);
        rst_n = 1'b1;
        tick(2);
        check("R1 released while cs high", 32'(sdo_en), 32'd0);
        cs_n = 1'b0; tick(2);
        check("R1 driven while cs low", 32'(sdo_en), 32'd1);
        check("R2 busy during conversion", 32'(sdo), 32'd1);
        tick(CONV + 2);
        check("R2 flag clear after conversion", 32'(sdo), 32'd0);
        frame(5'd3, pat(100));

        // R10 continuous conversions with select low, all addresses (R4, R5).
        for (int i = 0; i < 36; i++) begin
            result_in = (i < 32) ? pat(i) : edge_vals[i-32];
            tick(CONV + 3);
            check("R2 flag clear in continuous run", 32'(sdo), 32'd0);
            frame(ADDR_W'(i), result_in);
        end

        // R8: clocking during a conversion does nothing.
        result_in = 16'h5AA5;
        pulse(1'b1); pulse(1'b0); pulse(1'b1);
        check("R8 address unchanged in conversion", 32'(chan_addr), 32'd3);
        check("R8 still converting", 32'(sdo), 32'd1);
        tick(CONV);
        frame(5'd17, 16'h5AA5);

        // R3: sleep with select high, clock ignored, result held.
        cs_n = 1'b1; result_in = 16'h1234;
        tick(3);
        check("R1 released after cs rise", 32'(sdo_en), 32'd0);
        tick(CONV + 3);
        result_in = 16'hFFFF;
        pulse(1'b1); pulse(1'b0); pulse(1'b1);
        cs_n = 1'b0; tick(2);
        check("R3 still sleeping", 32'(sdo), 32'd0);
        frame(5'd9, 16'h1234);

        // R6/R7: abort one edge short of a full address.
        result_in = 16'hBEEF;
        tick(CONV + 3);
        pulse(1'b1); pulse(1'b1); pulse(1'b1); pulse(1'b1);
        cs_n = 1'b1; tick(2);
        check("R7 partial address discarded", 32'(chan_addr), 32'd9);
        result_in = 16'h0F0F;
        cs_n = 1'b0; tick(2);
        check("R6 abort restarts conversion", 32'(sdo), 32'd1);
        tick(CONV + 3);
        frame(5'd9, 16'h0F0F);

        // R7 boundary: abort right after the last address edge keeps it.
        tick(CONV + 3);
        pulse(1'b1); pulse(1'b0); pulse(1'b1); pulse(1'b1); pulse(1'b0);
        cs_n = 1'b1; tick(2);
        check("R7 full address kept on abort", 32'(chan_addr), 32'h16);
        result_in = 16'h7E81;
        cs_n = 1'b0; tick(2);
        check("R6 busy after abort", 32'(sdo), 32'd1);

        // R9: select fall with sck high selects the other mode.
        cs_n = 1'b1; tick(CONV + 3);
        sck = 1'b1; tick(1); cs_n = 1'b0; tick(2);
        check("R9 mode with sck high", 32'(ext_clk_mode), 32'd0);
        sck = 1'b0; tick(2);
        pulse(1'b1); pulse(1'b1);
        check("R9 no frame in other mode", 32'(sdo), 32'd0);
        cs_n = 1'b1; tick(2); cs_n = 1'b0; tick(2);
        check("R9 mode with sck low", 32'(ext_clk_mode), 32'd1);
        frame(5'd30, 16'h7E81);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule